// File: doc/BRIEF.md
# Next-PC and Address Generator

This block owns the program counter of a simple 32-bit load/store processor. Every cycle it decodes the opcode and function fields of the current instruction word and picks the next fetch address from four paths: fall-through to PC + 4, a conditional branch relative to the incremented PC, a jump into the current 256 MB region built from a 26-bit index, and a jump to an address held in a register. There is no delay slot. The selected address is written into the PC on a rising clock edge whenever the advance enable is high.

Alongside the fetch path, the block forms the effective address for loads and stores: the first register operand plus the sign-extended 16-bit immediate. It also presents the return address for linking calls, with a strobe that marks which instructions write it. The register file, ALU, memories and any pipelining sit outside the block.

Top module: `npc_addr_gen`

## Requirements
- R1: While `rst_n` is low, `pc` holds the `RESET_VEC` parameter (default 0x0040_0000).
- R2: On a rising clock edge `pc` takes the value `pc_next` had before the edge when `adv_en` is high, and keeps its value when `adv_en` is low.
- R3: Any opcode (instr[31:26]) other than 000000, 000010, 000011, 000100 and 000101 gives `pc_next` = `pc` + 4.
- R4: Opcode 000100 gives `pc_next` = branch target when `rs_val` equals `rt_val`, and `pc` + 4 otherwise.
- R5: Opcode 000101 gives `pc_next` = branch target when `rs_val` differs from `rt_val`, and `pc` + 4 otherwise.
- R6: The branch target is `pc` + 4 + (sign-extended instr[15:0] × 4), so a backward offset goes backward; from `pc` = 0x4000_000C with offset 2 it is 0x4000_0018.
- R7: Opcodes 000010 and 000011 give `pc_next` = {`pc`[31:28], instr[25:0], 2'b00}.
- R8: Opcode 000000 with function instr[5:0] = 001000 or 001001 gives `pc_next` = `rs_val` with bits 1:0 cleared; `misalign` is high in that case exactly when `rs_val`[1:0] is nonzero, and low for every other instruction.
- R9: `link_addr` always equals `pc` + 4; `link_we` is high for opcode 000011 and for opcode 000000 with function 001001, and low for every other instruction, including 000010 and function 001000.
- R10: `data_ea` equals `rs_val` plus instr[15:0] sign-extended to 32 bits, for every instruction word.
- R11: Opcode 000000 with any function other than 001000 and 001001 gives `pc_next` = `pc` + 4 and `link_we` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| adv_en | input | 1 | PC advance enable; low holds the PC |
| instr | input | 32 | Current instruction word |
| rs_val | input | 32 | Value of the first register operand |
| rt_val | input | 32 | Value of the second register operand |
| pc | output | 32 | Current program counter |
| pc_next | output | 32 | Address the PC takes at the next enabled edge |
| link_addr | output | 32 | Return address, PC + 4 |
| link_we | output | 1 | High when the instruction writes the return address |
| data_ea | output | 32 | Load/store effective address |
| misalign | output | 1 | Register-jump target had nonzero low bits |

## Verification
The collision of interest is a control transfer arriving in a cycle where the advance enable is low: the combinational `pc_next`, `link_we` and `misalign` must still show the transfer while the registered `pc` must not move. The random stream drops the enable in about a quarter of cycles, independently of the instruction class, so branches, jumps and register jumps all meet a stall. Each cycle is judged by comparing the outputs with a bench model before the edge and then comparing `pc` after the edge with either the predicted target or its own previous value.

// File: rtl/npc_pkg.sv
package npc_pkg;
   typedef enum logic [1:0] {
      PATH_SEQ    = 2'd0,
      PATH_BRANCH = 2'd1,
      PATH_JUMP   = 2'd2,
      PATH_REGJ   = 2'd3
   } path_e;

   localparam logic [5:0] OPC_SPECIAL = 6'b000000;
   localparam logic [5:0] OPC_JMP     = 6'b000010;
   localparam logic [5:0] OPC_JMPL    = 6'b000011;
   localparam logic [5:0] OPC_BR_EQ   = 6'b000100;
   localparam logic [5:0] OPC_BR_NE   = 6'b000101;
   localparam logic [5:0] FN_REGJ     = 6'b001000;
   localparam logic [5:0] FN_REGJL    = 6'b001001;
endpackage

// File: rtl/npc_decode.sv
module npc_decode
   import npc_pkg::*;
(
   input  logic [5:0] opcode,
   input  logic [5:0] funct,
   output path_e      path,
   output logic       br_on_ne,
   output logic       link
);
   always_comb begin
      path     = PATH_SEQ;
      br_on_ne = 1'b0;
      link     = 1'b0;
      unique case (opcode)
         OPC_SPECIAL: begin
            if (funct == FN_REGJ) begin
               path = PATH_REGJ;
            end else if (funct == FN_REGJL) begin
               path = PATH_REGJ;
               link = 1'b1;
            end
         end
         OPC_JMP:   path = PATH_JUMP;
         OPC_JMPL: begin
            path = PATH_JUMP;
            link = 1'b1;
         end
         OPC_BR_EQ: path = PATH_BRANCH;
         OPC_BR_NE: begin
            path     = PATH_BRANCH;
            br_on_ne = 1'b1;
         end
         default: path = PATH_SEQ;
      endcase
   end
endmodule

// File: rtl/npc_target.sv
module npc_target
   import npc_pkg::*;
#(
   parameter int XLEN       = 32,
   parameter int IMM_W      = 16,
   parameter int IDX_W      = 26,
   parameter int ALIGN_BITS = 2
) (
   input  logic [XLEN-1:0] pc,
   input  logic [XLEN-1:0] instr,
   input  logic [XLEN-1:0] rs_val,
   input  logic [XLEN-1:0] rt_val,
   input  path_e           path,
   input  logic            br_on_ne,
   output logic [XLEN-1:0] pc_next,
   output logic [XLEN-1:0] link_addr,
   output logic [XLEN-1:0] data_ea,
   output logic            misalign
);
   localparam int REGION_W = XLEN - IDX_W - ALIGN_BITS;
   localparam int EXT_W    = XLEN - IMM_W;
   localparam logic [XLEN-1:0] STEP = XLEN'(1) << ALIGN_BITS;

   generate
      if (REGION_W < 1) begin : g_bad_region
         $error("npc_target: XLEN too small for jump index and alignment");
      end
      if (EXT_W < 0) begin : g_bad_imm
         $error("npc_target: immediate wider than XLEN");
      end
   endgenerate

   logic [XLEN-1:0] pc_inc;
   logic [XLEN-1:0] imm_sx;
   logic [XLEN-1:0] br_tgt;
   logic [XLEN-1:0] jmp_tgt;
   logic [XLEN-1:0] reg_tgt;
   logic            ops_equal;
   logic            br_taken;

   assign pc_inc    = pc + STEP;
   assign imm_sx    = {{EXT_W{instr[IMM_W-1]}}, instr[IMM_W-1:0]};
   assign br_tgt    = pc_inc + (imm_sx << ALIGN_BITS);
   assign jmp_tgt   = {pc[XLEN-1 -: REGION_W], instr[IDX_W-1:0], {ALIGN_BITS{1'b0}}};
   assign reg_tgt   = {rs_val[XLEN-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
   assign ops_equal = (rs_val == rt_val);
   assign br_taken  = br_on_ne ? !ops_equal : ops_equal;

   assign link_addr = pc_inc;
   assign data_ea   = rs_val + imm_sx;
   assign misalign  = (path == PATH_REGJ) && (rs_val[ALIGN_BITS-1:0] != '0);

   always_comb begin
      unique case (path)
         PATH_BRANCH: pc_next = br_taken ? br_tgt : pc_inc;
         PATH_JUMP:   pc_next = jmp_tgt;
         PATH_REGJ:   pc_next = reg_tgt;
         default:     pc_next = pc_inc;
      endcase
   end
endmodule

// File: rtl/npc_pc_reg.sv
module npc_pc_reg #(
   parameter int               XLEN      = 32,
   parameter logic [XLEN-1:0]  RESET_VEC = '0
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            en,
   input  logic [XLEN-1:0] d,
   output logic [XLEN-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= RESET_VEC;
      else if (en) q <= d;
   end

   // R2: a stalled cycle leaves the PC untouched
   p_stall_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> $stable(q));
   // R2: an enabled cycle loads the offered address
   p_load_next_r2: assert property (@(posedge clk) disable iff (!rst_n)
      en |=> q == $past(d));
endmodule

// File: rtl/npc_addr_gen.sv
module npc_addr_gen
   import npc_pkg::*;
#(
   parameter int               XLEN       = 32,
   parameter int               IMM_W      = 16,
   parameter int               IDX_W      = 26,
   parameter int               ALIGN_BITS = 2,
   parameter logic [XLEN-1:0]  RESET_VEC  = 32'h0040_0000
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            adv_en,
   input  logic [XLEN-1:0] instr,
   input  logic [XLEN-1:0] rs_val,
   input  logic [XLEN-1:0] rt_val,
   output logic [XLEN-1:0] pc,
   output logic [XLEN-1:0] pc_next,
   output logic [XLEN-1:0] link_addr,
   output logic            link_we,
   output logic [XLEN-1:0] data_ea,
   output logic            misalign
);
   localparam int OPC_LSB = XLEN - 6;
   localparam logic [XLEN-1:0] STEP = XLEN'(1) << ALIGN_BITS;

   generate
      if (XLEN < 32) begin : g_bad_xlen
         $error("npc_addr_gen: opcode field needs XLEN of at least 32");
      end
      if (RESET_VEC[ALIGN_BITS-1:0] != '0) begin : g_bad_vec
         $error("npc_addr_gen: reset vector is not aligned");
      end
   endgenerate

   path_e path;
   logic  br_on_ne;
   logic  [5:0] opc;
   logic  [5:0] fn;

   assign opc = instr[XLEN-1:OPC_LSB];
   assign fn  = instr[5:0];

   npc_decode u_dec (
      .opcode   (opc),
      .funct    (fn),
      .path     (path),
      .br_on_ne (br_on_ne),
      .link     (link_we)
   );

   npc_target #(
      .XLEN       (XLEN),
      .IMM_W      (IMM_W),
      .IDX_W      (IDX_W),
      .ALIGN_BITS (ALIGN_BITS)
   ) u_tgt (
      .pc        (pc),
      .instr     (instr),
      .rs_val    (rs_val),
      .rt_val    (rt_val),
      .path      (path),
      .br_on_ne  (br_on_ne),
      .pc_next   (pc_next),
      .link_addr (link_addr),
      .data_ea   (data_ea),
      .misalign  (misalign)
   );

   npc_pc_reg #(
      .XLEN      (XLEN),
      .RESET_VEC (RESET_VEC)
   ) u_pc (
      .clk   (clk),
      .rst_n (rst_n),
      .en    (adv_en),
      .d     (pc_next),
      .q     (pc)
   );

   // R3: ordinary opcodes fall through by one word
   p_seq_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (opc != OPC_SPECIAL && opc != OPC_JMP && opc != OPC_JMPL &&
       opc != OPC_BR_EQ && opc != OPC_BR_NE) |-> pc_next == pc + STEP);
   // R8: a flagged register jump still yields an aligned target
   p_misalign_fix_r8: assert property (@(posedge clk) disable iff (!rst_n)
      misalign |-> (pc_next[ALIGN_BITS-1:0] == '0 && opc == OPC_SPECIAL));
   // R9: link strobe only for the two linking forms
   p_link_kind_r9: assert property (@(posedge clk) disable iff (!rst_n)
      link_we |-> (opc == OPC_JMPL || (opc == OPC_SPECIAL && fn == FN_REGJL)));
   // R7: a region jump never leaves the current region
   p_region_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (opc == OPC_JMP || opc == OPC_JMPL) |->
         pc_next[XLEN-1 -: (XLEN-IDX_W-ALIGN_BITS)] == pc[XLEN-1 -: (XLEN-IDX_W-ALIGN_BITS)]);
   // R11: other special functions neither jump nor link
   p_special_seq_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (opc == OPC_SPECIAL && fn != FN_REGJ && fn != FN_REGJL) |->
         (pc_next == pc + STEP && !link_we && !misalign));
endmodule

// File: tb/npc_addr_gen_test.sv
module npc_addr_gen_test;
   localparam logic [31:0] RST_VEC = 32'h0040_0000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        adv_en = 1'b0;
   logic [31:0] instr = '0;
   logic [31:0] rs_val = '0;
   logic [31:0] rt_val = '0;
   logic [31:0] pc, pc_next, link_addr, data_ea;
   logic        link_we, misalign;

   int checks = 0;
   int failures = 0;
   logic [31:0] exp_pc;
   bit done = 1'b0;

   always #5 clk = ~clk;

   npc_addr_gen #(.RESET_VEC(RST_VEC)) uut (
      .clk(clk), .rst_n(rst_n), .adv_en(adv_en), .instr(instr),
      .rs_val(rs_val), .rt_val(rt_val), .pc(pc), .pc_next(pc_next),
      .link_addr(link_addr), .link_we(link_we), .data_ea(data_ea),
      .misalign(misalign)
   );

   function automatic logic [31:0] sx16(input logic [15:0] v);
      return {{16{v[15]}}, v};
   endfunction

   function automatic bit is_regj(input logic [31:0] w);
      return w[31:26] == 6'd0 && (w[5:0] == 6'b001000 || w[5:0] == 6'b001001);
   endfunction

   function automatic logic [31:0] model_next(input logic [31:0] p, w, a, b);
      logic [31:0] inc;
      inc = p + 32'd4;
      if (is_regj(w)) return {a[31:2], 2'b00};
      case (w[31:26])
         6'b000010, 6'b000011: return {p[31:28], w[25:0], 2'b00};
         6'b000100: return (a == b) ? inc + (sx16(w[15:0]) << 2) : inc;
         6'b000101: return (a != b) ? inc + (sx16(w[15:0]) << 2) : inc;
         default:   return inc;
      endcase
   endfunction

   function automatic bit model_link(input logic [31:0] w);
      return w[31:26] == 6'b000011 || (w[31:26] == 6'd0 && w[5:0] == 6'b001001);
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // drive one instruction at the falling edge, check combinational outputs,
   // then let the rising edge happen; pc is checked at the next step
   task automatic step(input string req, input bit en, input logic [31:0] w, a, b);
      @(negedge clk);
      chk({req, " pc R2"}, pc, exp_pc);
      adv_en = en; instr = w; rs_val = a; rt_val = b;
      #1;
      chk({req, " pc_next"}, pc_next, model_next(exp_pc, w, a, b));
      chk("R9 link_addr", link_addr, exp_pc + 32'd4);
      chk("R9 link_we", 32'(link_we), 32'(model_link(w)));
      chk("R10 data_ea", data_ea, a + sx16(w[15:0]));
      chk("R8 misalign", 32'(misalign), 32'(is_regj(w) && a[1:0] != 2'b00));
      if (en) exp_pc = model_next(exp_pc, w, a, b);
   endtask

   function automatic logic [31:0] mk_i(input logic [5:0] op, input logic [25:0] rest);
      return {op, rest};
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         failures++;
         checks++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20161214));
      exp_pc = RST_VEC;
      repeat (2) @(negedge clk);
      chk("R1 reset pc", pc, RST_VEC);
      @(negedge clk);
      rst_n = 1'b1;

      // R3 plain sequential advance and R2 stall
      step("R3", 1'b1, mk_i(6'b100011, 26'h0000_0010), 32'h0000_1000, 0);
      step("R2 stall", 1'b0, mk_i(6'b001000, 26'h0), 0, 0);
      // R10 negative displacement: 0x1000 + (-4) = 0xFFC
      step("R10", 1'b1, mk_i(6'b101011, 26'h000_FFFC), 32'h0000_1000, 0);
      // R8 register jump to 0x4000000C (aligned)
      step("R8", 1'b1, mk_i(6'd0, 26'h0000_0008), 32'h4000_000C, 0);
      // R6 worked example: taken equal-branch, offset 2 -> 0x40000018
      step("R6 R4", 1'b1, mk_i(6'b000100, 26'h0000_0002), 32'h5, 32'h5);
      // R4 untaken
      step("R4 untaken", 1'b1, mk_i(6'b000100, 26'h0000_0002), 32'h5, 32'h6);
      // R5 taken backward (offset -3), then untaken
      step("R5 R6 back", 1'b1, mk_i(6'b000101, 26'h000_FFFD), 32'h1, 32'h2);
      step("R5 untaken", 1'b1, mk_i(6'b000101, 26'h000_FFFD), 32'h7, 32'h7);
      // R7 region jump without and with link
      step("R7 jmp", 1'b1, mk_i(6'b000010, 26'h145_0BD6), 0, 0);
      step("R7 R9 jmpl", 1'b1, mk_i(6'b000011, 26'h000_0040), 0, 0);
      // R8 misaligned linking register jump, stalled then taken
      step("R8 R9 stall", 1'b0, mk_i(6'd0, 26'h0000_0009), 32'h0000_2003, 0);
      step("R8 R9 regjl", 1'b1, mk_i(6'd0, 26'h0000_0009), 32'h0000_2003, 0);
      // R11 other special function
      step("R11", 1'b1, mk_i(6'd0, 26'h0000_0020), 32'h0000_3000, 0);

      for (int i = 0; i < 3000; i++) begin
         logic [31:0] w, a, b;
         logic [5:0]  op;
         bit          en;
         int          k;
         k  = int'($urandom % 8);
         w  = $urandom;
         a  = $urandom;
         b  = $urandom;
         en = ($urandom % 4) != 0;
         case (k)
            0: begin w[31:26] = 6'b000100; if ($urandom % 2) b = a; end
            1: begin w[31:26] = 6'b000101; if ($urandom % 2) b = a; end
            2: w[31:26] = 6'b000010;
            3: w[31:26] = 6'b000011;
            4: begin w[31:26] = 6'd0; w[5:0] = 6'b001000; end
            5: begin w[31:26] = 6'd0; w[5:0] = 6'b001001; end
            6: begin
               w[31:26] = 6'd0;
               if (w[5:0] == 6'b001000 || w[5:0] == 6'b001001) w[5:0] = 6'b100001;
            end
            default: begin
               op = w[31:26];
               if (op <= 6'd5) op = 6'b100011;
               w[31:26] = op;
            end
         endcase
         step(k < 2 ? "R4 R5 rand" : k < 4 ? "R7 rand" : k < 6 ? "R8 rand" :
              k == 6 ? "R11 rand" : "R3 rand", en, w, a, b);
      end
      @(negedge clk);
      chk("R2 final pc", pc, exp_pc);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule